// File: doc/BRIEF.md
# Six-Port Out-of-Order Issue Scheduler

This block is a pool of renamed micro-ops that wait for their operands. Each held micro-op carries two source tags and one ready flag per source. It also carries the number of the one execution port that may run it, and an opaque identifier that the block returns when the micro-op issues. The block watches the result-tag broadcast lanes and marks any waiting source whose tag matches as ready. When both sources are ready, the micro-op becomes a candidate for its port.

Every cycle each of the six ports independently issues its oldest candidate. Program order only breaks ties among candidates. An old micro-op that is still waiting, for example one that needs a load's result, never blocks a younger micro-op that is ready. An issued micro-op leaves the pool at the same clock edge. One micro-op can be allocated per cycle, into the lowest-numbered free slot. When no slot is free, allocation stalls.

Top module: `rs_sched`

## Requirements
- R1: The pool holds at most DEPTH (default 36) micro-ops. `alloc_ready` is high exactly when at least one slot is free. A request made while `alloc_ready` is low is dropped and never issues.
- R2: A source becomes ready at the clock edge where a valid broadcast lane carries its tag. The micro-op is offered on its port from the cycle after the edge at which its last source became ready.
- R3: A broadcast at the same edge as an allocation marks the new micro-op's matching sources ready. If both sources end up ready, the micro-op is offered in the very next cycle.
- R4: `alloc_cls` holds the port number: 0, 1 and 2 are the arithmetic/complex ports, 3 is load address, 4 is store address and 5 is store data. Port p offers only micro-ops whose class equals p.
- R5: Among the ready micro-ops of one class, the one allocated earliest is offered. Older micro-ops that are not ready are skipped for as long as they stay not ready.
- R6: Each port offers at most one micro-op per cycle. An offered micro-op is removed at the next edge. A slot freed at an edge can be allocated in the following cycle, so `alloc_ready` rises in the cycle after an issue from a full pool.
- R7: After reset the pool is empty: every `disp_valid` bit is low and `alloc_ready` is high.
- R8: A micro-op with a source that has not been marked ready is never offered, whatever its age.
- R9: Either broadcast lane can wake a source. A lane whose valid bit is low wakes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_src_tag | input | NUM_SRC*TAG_W | Source tags, source 0 in the low bits |
| alloc_src_rdy | input | NUM_SRC | Source already available at allocation |
| alloc_cls | input | CLS_W | Target port number (class) |
| alloc_id | input | ID_W | Opaque identifier returned at issue |
| alloc_ready | output | 1 | At least one free slot |
| bc_valid | input | NUM_BC | Broadcast lane valid |
| bc_tag | input | NUM_BC*TAG_W | Broadcast result tags, lane 0 in the low bits |
| disp_valid | output | NUM_PORTS | Port p issues this cycle |
| disp_id | output | NUM_PORTS*ID_W | Identifier issued on port p, port 0 in the low bits |

## Verification
On every cycle, the assertions check several invariants. Each port grant is at most one-hot, and every issued micro-op is live, fully ready and of the port's class. A non-empty candidate set always yields a grant. Issued slots are empty after the edge, broadcasts set the matching ready flags (including for the slot being written), and allocation never lands on a live slot. Only the bench's reference model can show issue order: that the earliest ready micro-op wins, that stalled older ones are passed, that dropped requests never reappear, and that a slot returns to use one cycle after it drains from a full pool.

// File: rtl/rs_sched_pkg.sv
package rs_sched_pkg;

    // Port numbers double as micro-op class codes.
    typedef enum logic [2:0] {
        PCLS_ARITH0 = 3'd0,
        PCLS_ARITH1 = 3'd1,
        PCLS_ARITH2 = 3'd2,
        PCLS_LDADDR = 3'd3,
        PCLS_STADDR = 3'd4,
        PCLS_STDATA = 3'd5
    } port_cls_e;

    localparam int unsigned PORT_COUNT = 6;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/rs_free_find.sv
module rs_free_find #(
    parameter  int unsigned DEPTH = 36,
    localparam int unsigned IDX_W = rs_sched_pkg::idx_width(DEPTH)
) (
    input  logic [DEPTH-1:0] busy,
    output logic             found,
    output logic [IDX_W-1:0] slot
);

    // Lowest-numbered free slot wins.
    always_comb begin
        found = 1'b0;
        slot  = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                slot  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/rs_tag_match.sv
module rs_tag_match #(
    parameter int unsigned TAG_W  = 6,
    parameter int unsigned NUM_BC = 2
) (
    input  logic [TAG_W-1:0]        tag,
    input  logic [NUM_BC-1:0]       bc_valid,
    input  logic [NUM_BC*TAG_W-1:0] bc_tag,
    output logic                    hit
);

    always_comb begin
        hit = 1'b0;
        for (int b = 0; b < NUM_BC; b++) begin
            if (bc_valid[b] && (bc_tag[b*TAG_W +: TAG_W] == tag)) begin
                hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_age_pick.sv
module rs_age_pick #(
    parameter  int unsigned DEPTH = 36,
    localparam int unsigned IDX_W = rs_sched_pkg::idx_width(DEPTH)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [DEPTH-1:0]            req,
    // older[i][j] set: slot j was allocated before slot i
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    output logic [DEPTH-1:0]            grant,
    output logic                        found,
    output logic [IDX_W-1:0]            idx
);

    // A requester wins when no other requester is older than it.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            grant[i] = req[i] && ((req & older[i]) == '0);
        end
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

    // R6: at most one winner per port and cycle
    assert_grant_onehot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R5: a consistent age order always yields an oldest candidate
    assert_grant_exists_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));

endmodule

// File: rtl/rs_sched.sv
module rs_sched #(
    parameter  int unsigned DEPTH     = 36,
    parameter  int unsigned NUM_PORTS = rs_sched_pkg::PORT_COUNT,
    parameter  int unsigned NUM_SRC   = 2,
    parameter  int unsigned NUM_BC    = 2,
    parameter  int unsigned TAG_W     = 6,
    parameter  int unsigned ID_W      = 8,
    localparam int unsigned CLS_W     = rs_sched_pkg::idx_width(NUM_PORTS),
    localparam int unsigned IDX_W     = rs_sched_pkg::idx_width(DEPTH)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    input  logic [NUM_SRC*TAG_W-1:0]     alloc_src_tag,
    input  logic [NUM_SRC-1:0]           alloc_src_rdy,
    input  logic [CLS_W-1:0]             alloc_cls,
    input  logic [ID_W-1:0]              alloc_id,
    output logic                         alloc_ready,
    input  logic [NUM_BC-1:0]            bc_valid,
    input  logic [NUM_BC*TAG_W-1:0]      bc_tag,
    output logic [NUM_PORTS-1:0]         disp_valid,
    output logic [NUM_PORTS*ID_W-1:0]    disp_id
);

    typedef struct packed {
        logic                            valid;
        logic [NUM_SRC-1:0]              rdy;
        logic [NUM_SRC-1:0][TAG_W-1:0]   src;
        logic [CLS_W-1:0]                cls;
        logic [ID_W-1:0]                 id;
    } slot_t;

    typedef struct packed {
        slot_t [DEPTH-1:0]               ent;
        logic  [DEPTH-1:0][DEPTH-1:0]    older;
    } pool_t;

    pool_t pool_q, pool_d;

    logic [DEPTH-1:0]                  busy;
    logic [NUM_PORTS-1:0][DEPTH-1:0]   req;
    logic [NUM_PORTS-1:0][DEPTH-1:0]   grant;
    logic [NUM_PORTS-1:0][IDX_W-1:0]   pick_idx;
    logic [NUM_PORTS-1:0]              pick_found;
    logic [DEPTH-1:0]                  freed;
    logic [DEPTH-1:0][NUM_SRC-1:0]     ent_hit;
    logic [NUM_SRC-1:0]                new_hit;
    logic                              slot_ok;
    logic [IDX_W-1:0]                  slot;
    logic                              alloc_fire;

    // ---------------- free-slot search ----------------
    for (genvar i = 0; i < DEPTH; i++) begin : g_busy
        assign busy[i] = pool_q.ent[i].valid;
    end

    rs_free_find #(.DEPTH(DEPTH)) u_free (
        .busy  (busy),
        .found (slot_ok),
        .slot  (slot)
    );

    assign alloc_ready = slot_ok;
    assign alloc_fire  = alloc_valid && slot_ok;

    // ---------------- wakeup ----------------
    for (genvar i = 0; i < DEPTH; i++) begin : g_wake
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            rs_tag_match #(.TAG_W(TAG_W), .NUM_BC(NUM_BC)) u_match (
                .tag      (pool_q.ent[i].src[s]),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .hit      (ent_hit[i][s])
            );
        end
    end

    for (genvar s = 0; s < NUM_SRC; s++) begin : g_new_wake
        rs_tag_match #(.TAG_W(TAG_W), .NUM_BC(NUM_BC)) u_match (
            .tag      (alloc_src_tag[s*TAG_W +: TAG_W]),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .hit      (new_hit[s])
        );
    end

    // ---------------- per-port selection ----------------
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        for (genvar i = 0; i < DEPTH; i++) begin : g_req
            assign req[p][i] = pool_q.ent[i].valid
                             && (&pool_q.ent[i].rdy)
                             && (pool_q.ent[i].cls == CLS_W'(p));
        end

        rs_age_pick #(.DEPTH(DEPTH)) u_pick (
            .clk   (clk),
            .rst_n (rst_n),
            .req   (req[p]),
            .older (pool_q.older),
            .grant (grant[p]),
            .found (pick_found[p]),
            .idx   (pick_idx[p])
        );

        assign disp_valid[p]              = pick_found[p];
        assign disp_id[p*ID_W +: ID_W]    = pool_q.ent[pick_idx[p]].id;

        // R4: an issued micro-op is live, fully ready and of this port's class
        assert_disp_class_R4: assert property (@(posedge clk) disable iff (!rst_n)
            disp_valid[p] |-> (pool_q.ent[pick_idx[p]].valid
                               && (&pool_q.ent[pick_idx[p]].rdy)
                               && (pool_q.ent[pick_idx[p]].cls == CLS_W'(p))));
    end

    always_comb begin
        freed = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            freed = freed | grant[p];
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        pool_d = pool_q;

        for (int i = 0; i < DEPTH; i++) begin
            if (freed[i]) begin
                pool_d.ent[i].valid = 1'b0;
            end
            pool_d.ent[i].rdy = pool_q.ent[i].rdy | ent_hit[i];
        end

        if (alloc_fire) begin
            pool_d.ent[slot].valid = 1'b1;
            pool_d.ent[slot].rdy   = alloc_src_rdy | new_hit;
            pool_d.ent[slot].src   = alloc_src_tag;
            pool_d.ent[slot].cls   = alloc_cls;
            pool_d.ent[slot].id    = alloc_id;
            for (int k = 0; k < DEPTH; k++) begin
                pool_d.older[k][slot] = 1'b0;
            end
            pool_d.older[slot] = busy & ~freed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pool_q <= '0;
        end else begin
            pool_q <= pool_d;
        end
    end

    // ---------------- assertions ----------------
    // R1: allocation only lands on a slot that is empty
    assert_alloc_empty_slot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_fire |-> !pool_q.ent[slot].valid);

    for (genvar i = 0; i < DEPTH; i++) begin : g_chk
        // R6: an issued slot is empty after the edge
        assert_freed_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
            freed[i] |=> !pool_q.ent[i].valid);

        for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk_src
            // R2: a matching broadcast marks a waiting source ready
            assert_wake_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
                (pool_q.ent[i].valid && !freed[i] && ent_hit[i][s])
                |=> pool_q.ent[i].rdy[s]);

            // R3: a broadcast at the allocation edge reaches the new slot
            assert_wake_alloc_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (alloc_fire && (slot == IDX_W'(i)) && new_hit[s])
                |=> (pool_q.ent[i].valid && pool_q.ent[i].rdy[s]));
        end
    end

endmodule

// File: tb/rs_sched_bench.sv
module rs_sched_bench;

    localparam int DEPTH = 36;
    localparam int NPORT = 6;
    localparam int NSRC  = 2;
    localparam int NBC   = 2;
    localparam int TAG_W = 6;
    localparam int ID_W  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;   // 4 ns period

    logic                    alloc_valid;
    logic [NSRC*TAG_W-1:0]   alloc_src_tag;
    logic [NSRC-1:0]         alloc_src_rdy;
    logic [2:0]              alloc_cls;
    logic [ID_W-1:0]         alloc_id;
    logic                    alloc_ready;
    logic [NBC-1:0]          bc_valid;
    logic [NBC*TAG_W-1:0]    bc_tag;
    logic [NPORT-1:0]        disp_valid;
    logic [NPORT*ID_W-1:0]   disp_id;

    rs_sched u_rs_sched (
        .clk           (clk),
        .rst_n         (rst_n),
        .alloc_valid   (alloc_valid),
        .alloc_src_tag (alloc_src_tag),
        .alloc_src_rdy (alloc_src_rdy),
        .alloc_cls     (alloc_cls),
        .alloc_id      (alloc_id),
        .alloc_ready   (alloc_ready),
        .bc_valid      (bc_valid),
        .bc_tag        (bc_tag),
        .disp_valid    (disp_valid),
        .disp_id       (disp_id)
    );

    // reference pool
    bit m_v   [DEPTH];
    int m_tag [DEPTH][NSRC];
    bit m_r   [DEPTH][NSRC];
    int m_cls [DEPTH];
    int m_id  [DEPTH];
    int m_age [DEPTH];

    int    seq    = 0;
    int    n_chk  = 0;
    int    n_fail = 0;
    bit    done   = 1'b0;
    string phase  = "R7";

    function automatic int live_count();
        int n = 0;
        for (int i = 0; i < DEPTH; i++) if (m_v[i]) n++;
        return n;
    endfunction

    function automatic int oldest_ready(input int p);
        int best = -1;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_v[i] && m_r[i][0] && m_r[i][1] && m_cls[i] == p
                && (best < 0 || m_age[i] < m_age[best])) best = i;
        end
        return best;
    endfunction

    function automatic bit woken(input int tag, input bit b0v, input int b0t,
                                 input bit b1v, input int b1t);
        return (b0v && b0t == tag) || (b1v && b1t == tag);
    endfunction

    task automatic step(input bit av, input int t0, input int t1,
                        input bit r0, input bit r1, input int cls,
                        input bit b0v, input int b0t, input bit b1v, input int b1t);
        int exp_pick [NPORT];
        bit full;
        @(negedge clk);
        full = (live_count() == DEPTH);
        n_chk++;
        if (alloc_ready !== !full) begin
            n_fail++;
            $display("FAIL R1 alloc_ready: got %0b expected %0b", alloc_ready, !full);
        end
        for (int p = 0; p < NPORT; p++) begin
            exp_pick[p] = oldest_ready(p);
            n_chk++;
            if (exp_pick[p] < 0) begin
                if (disp_valid[p] !== 1'b0) begin
                    n_fail++;
                    $display("FAIL %s port %0d: got valid=%0b id=%0d expected valid=0",
                             phase, p, disp_valid[p], disp_id[p*ID_W +: ID_W]);
                end
            end else if (disp_valid[p] !== 1'b1
                         || disp_id[p*ID_W +: ID_W] !== ID_W'(m_id[exp_pick[p]])) begin
                n_fail++;
                $display("FAIL %s port %0d: got valid=%0b id=%0d expected valid=1 id=%0d",
                         phase, p, disp_valid[p], disp_id[p*ID_W +: ID_W],
                         m_id[exp_pick[p]] & 255);
            end
        end
        // drive this cycle's inputs
        alloc_valid   = av;
        alloc_src_tag = {TAG_W'(t1), TAG_W'(t0)};
        alloc_src_rdy = {r1, r0};
        alloc_cls     = 3'(cls);
        alloc_id      = ID_W'(seq);
        bc_valid      = {b1v, b0v};
        bc_tag        = {TAG_W'(b1t), TAG_W'(b0t)};
        // reference next state
        for (int p = 0; p < NPORT; p++) if (exp_pick[p] >= 0) m_v[exp_pick[p]] = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (m_v[i]) begin
                for (int s = 0; s < NSRC; s++)
                    if (woken(m_tag[i][s], b0v, b0t, b1v, b1t)) m_r[i][s] = 1'b1;
            end
        end
        if (av && !full) begin
            int slot = -1;
            for (int i = DEPTH - 1; i >= 0; i--) if (!m_v[i]) slot = i;
            m_v[slot]      = 1'b1;
            m_tag[slot][0] = t0;
            m_tag[slot][1] = t1;
            m_r[slot][0]   = r0 || woken(t0, b0v, b0t, b1v, b1t);
            m_r[slot][1]   = r1 || woken(t1, b0v, b0t, b1v, b1t);
            m_cls[slot]    = cls;
            m_id[slot]     = seq & 255;
            m_age[slot]    = seq;
            seq++;
        end
    endtask

    task automatic idle();
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL R7 watchdog: got still running expected finished");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        alloc_valid = 1'b0; alloc_src_tag = '0; alloc_src_rdy = '0;
        alloc_cls = '0; alloc_id = '0; bc_valid = '0; bc_tag = '0;
        for (int i = 0; i < DEPTH; i++) m_v[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R7: empty after reset
        phase = "R7";
        idle(); idle();

        // R3 and R9: lane 1 wakes the source being allocated
        phase = "R3";
        step(1'b1, 5, 6, 1'b0, 1'b1, 2, 1'b0, 0, 1'b1, 5);
        idle();
        phase = "R9";
        step(1'b1, 7, 7, 1'b0, 1'b0, 3, 1'b0, 7, 1'b0, 0);   // lane valid low: no wake
        idle(); idle();
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b1, 7, 1'b0, 0);
        idle();

        // R2: readiness arrives one source at a time
        phase = "R2";
        step(1'b1, 8, 9, 1'b0, 1'b0, 4, 1'b0, 0, 1'b0, 0);
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b1, 8, 1'b0, 0);
        idle();
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b0, 0, 1'b1, 9);
        idle(); idle();

        // R8 and R5: old load-dependent op waits, young ready op passes it
        phase = "R8";
        step(1'b1, 11, 12, 1'b0, 1'b0, 0, 1'b0, 0, 1'b0, 0);
        step(1'b1, 0, 0, 1'b1, 1'b1, 0, 1'b0, 0, 1'b0, 0);
        step(1'b1, 0, 0, 1'b1, 1'b1, 0, 1'b0, 0, 1'b0, 0);
        repeat (5) idle();
        phase = "R5";
        step(1'b1, 0, 0, 1'b1, 1'b1, 0, 1'b1, 11, 1'b1, 12);
        idle(); idle(); idle();

        // R1: fill the pool with stalled ops, then push while full
        phase = "R1";
        for (int k = 0; k < DEPTH + 4; k++)
            step(1'b1, 63, 63, 1'b0, 1'b0, 1, 1'b0, 0, 1'b0, 0);
        repeat (4) step(1'b1, 0, 0, 1'b1, 1'b1, 1, 1'b0, 0, 1'b0, 0);

        // R6: release everything; drains oldest first, slot reused after one cycle
        phase = "R6";
        step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b1, 63, 1'b0, 0);
        for (int k = 0; k < DEPTH + 8; k++)
            step(1'b1, 0, 0, 1'b1, 1'b1, 5, 1'b0, 0, 1'b0, 0);
        repeat (4) idle();

        // R4: constrained random traffic over all classes
        phase = "R4";
        for (int k = 0; k < 3000; k++) begin
            step($urandom_range(0, 9) < 7,
                 int'($urandom_range(0, 62)), int'($urandom_range(0, 62)),
                 $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1,
                 int'($urandom_range(0, 5)),
                 $urandom_range(0, 1) == 1, int'($urandom_range(0, 62)),
                 $urandom_range(0, 1) == 1, int'($urandom_range(0, 62)));
        end
        for (int k = 0; k < 64; k++)
            step(1'b0, 0, 0, 1'b0, 1'b0, 0, 1'b1, k, 1'b0, 0);
        repeat (10) idle();

        done = 1'b1;
        finish_run();
    end

endmodule